// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the register-access slave for a sensor front end that is reached over a three-wire serial bus: a frame enable, a serial clock and one shared data line. Each frame starts with an eight-bit header: a direction bit, a three-bit device identifier and a four-bit address. The data follows the header. The block accepts a frame only when the identifier matches its own. It returns read data on the same wire, which it turns around halfway through the frame. The pad is split into an input, an output and an output enable.

Behind the port there is a sixteen-address register space. Three registers are shared by both banks: two control registers and a miscellaneous register. Nine addresses map to whichever bank the miscellaneous register selects. A four-byte sample store is filled by the converter's decimation stage. Its bytes are paired into two halves, and a longer 24-clock read returns one half. All serial lines are resynchronised into the block clock, so the serial clock must be much slower than the block clock.

Top module: `serialRegPort`

## Requirements
- R1: The slave captures bits on rising SPC edges inside a frame (spe high). The bit order is: direction (1 = read), ID[2:0], address[3:0], data[7:0], each field MSB first. A write takes effect only when the frame ends after exactly 16 clocks.
- R2: A frame whose ID field is not 3'b110 writes nothing, and sdOe stays low for the whole frame.
- R3: On a valid read, sdOe is low during bits 0 to 7. From the falling edge that starts bit 8, the slave drives the data MSB first, one bit per falling edge.
- R4: After rstN, address 0x4 reads 0x40, address 0x5 reads 0x63, address 0xF reads 0x20, and every banked address reads 0x00.
- R5: Addresses 0x6 to 0xE are separate storage per bank. Bank 1 is selected exactly when the low two bits of the register at 0xF are 2'b01. Addresses 0x4, 0x5 and 0xF are common to both banks.
- R6: A write to 0xF with bit 7 set restores every register to its R4 value. This also selects bank 0.
- R7: A 24-clock read at address 0x0 returns the first two stored samples, and one at address 0x2 returns the third and fourth. Each is 16 bits with the earlier-stored byte first, MSB first. A 16-clock read at these addresses returns only the earlier byte.
- R8: After a valid 24-clock read at 0x0 or 0x2, the next stored sample goes to the first slot. Samples that arrive while all four slots are full are dropped.
- R9: Addresses 0x1 and 0x3 read 0x00. Writes to 0x0, 0x1, 0x2 and 0x3 change nothing.
- R10: A frame that ends before its 16th clock writes nothing. sdOe drops in the same cycle that spe goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than spc |
| rstN | input | 1 | Active-low synchronous reset |
| spe | input | 1 | Frame enable, high for the duration of a frame |
| spc | input | 1 | Serial clock, idles high |
| sdIn | input | 1 | Data line as seen from the pad |
| sdOut | output | 1 | Data the slave drives onto the line |
| sdOe | output | 1 | Pad output enable for sdOut |
| sampleStrobe | input | 1 | Stores sampleByte into the next sample slot |
| sampleByte | input | 8 | Converter output byte |

## Verification
The assertions assume that spe changes only while spc is high, and that spc stays at each level for several block clocks, so that every serial edge is seen as exactly one synchronised edge. The bench holds each spc level for eight block clocks. It raises and lowers spe only with spc high, and it changes sdIn only on the falling half of the serial clock. It pulses sampleStrobe only between frames, so no sample store coincides with the end of a sample read.

// File: rtl/serialRegPkg.sv
package serialRegPkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ID_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_SAMPLE_LO = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SAMPLE_HI = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_A    = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_B    = 4'h5;
  localparam logic [ADDR_W-1:0] ADDR_BANK_LO   = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_BANK_HI   = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_MISC      = 4'hF;

  localparam logic [DATA_W-1:0] RST_CTRL_A = 8'h40;
  localparam logic [DATA_W-1:0] RST_CTRL_B = 8'h63;
  localparam logic [DATA_W-1:0] RST_MISC   = 8'h20;

  typedef struct packed {
    logic              wrEn;
    logic              fifoRestart;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wrData;
  } portStrobeT;
endpackage

// File: rtl/serialPortCtrl.sv
module serialPortCtrl
  import serialRegPkg::*;
#(
  parameter logic [ID_W-1:0] CHIP_ID     = 3'b110,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spe,
  input  logic                spc,
  input  logic                sdIn,
  input  logic [2*DATA_W-1:0] readWord,
  output portStrobeT          strobe,
  output logic                sdOut,
  output logic                sdOe
);
  localparam int HDR_BITS  = 1 + ID_W + ADDR_W;
  localparam int REG_BITS  = HDR_BITS + DATA_W;
  localparam int FIFO_BITS = HDR_BITS + 2 * DATA_W;
  localparam int CNT_W     = $clog2(FIFO_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] speSync, spcSync, sdiSync;
  logic speQ, spcQ;
  logic speNow, spcNow, sdiNow;
  logic speRise, speFall, spcRise, spcFall;

  assign speNow = speSync[SYNC_STAGES-1];
  assign spcNow = spcSync[SYNC_STAGES-1];
  assign sdiNow = sdiSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speSync <= '0;
      spcSync <= '1;
      sdiSync <= '0;
      speQ    <= 1'b0;
      spcQ    <= 1'b1;
    end else begin
      speSync <= {speSync[SYNC_STAGES-2:0], spe};
      spcSync <= {spcSync[SYNC_STAGES-2:0], spc};
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdIn};
      speQ    <= speNow;
      spcQ    <= spcNow;
    end
  end

  assign speRise = speNow && !speQ;
  assign speFall = !speNow && speQ;
  assign spcRise = speNow && spcNow && !spcQ;
  assign spcFall = speNow && !spcNow && spcQ;

  logic [CNT_W-1:0]    rxCnt;
  logic [REG_BITS-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN || speRise) begin
      rxCnt   <= '0;
      rxShift <= '0;
    end else if (spcRise) begin
      if (rxCnt < CNT_W'(REG_BITS)) rxShift <= {rxShift[REG_BITS-2:0], sdiNow};
      if (rxCnt != CNT_MAX) rxCnt <= rxCnt + CNT_W'(1);
    end
  end

  logic [HDR_BITS-1:0] hdr;
  logic                rwBit, idOk, sampleAddr;
  logic [ADDR_W-1:0]   addrBits;

  assign hdr        = (rxCnt >= CNT_W'(REG_BITS)) ? rxShift[REG_BITS-1:DATA_W]
                                                  : rxShift[HDR_BITS-1:0];
  assign rwBit      = hdr[HDR_BITS-1];
  assign idOk       = (hdr[HDR_BITS-2 -: ID_W] == CHIP_ID);
  assign addrBits   = hdr[ADDR_W-1:0];
  assign sampleAddr = (addrBits == ADDR_SAMPLE_LO) || (addrBits == ADDR_SAMPLE_HI);

  logic                loaded, driving;
  logic [2*DATA_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN || speRise || speFall) begin
      loaded  <= 1'b0;
      driving <= 1'b0;
      txShift <= '0;
    end else if (spcFall) begin
      if (!loaded && rxCnt == CNT_W'(HDR_BITS)) begin
        loaded  <= 1'b1;
        driving <= rwBit && idOk;
        txShift <= readWord;
      end else if (driving) begin
        txShift <= {txShift[2*DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdOut = txShift[2*DATA_W-1];
  assign sdOe  = driving && spe;

  always_comb begin
    strobe             = '0;
    strobe.addr        = addrBits;
    strobe.wrData      = rxShift[DATA_W-1:0];
    strobe.wrEn        = speFall && rxCnt == CNT_W'(REG_BITS) && !rwBit && idOk;
    strobe.fifoRestart = speFall && rxCnt == CNT_W'(FIFO_BITS) && rwBit && idOk && sampleAddr;
  end
endmodule

// File: rtl/serialRegData.sv
module serialRegData
  import serialRegPkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobeT          strobe,
  input  logic                sampleStrobe,
  input  logic [DATA_W-1:0]   sampleByte,
  output logic [2*DATA_W-1:0] readWord
);
  localparam int BANK_SPAN = int'(ADDR_BANK_HI) - int'(ADDR_BANK_LO) + 1;
  localparam int PTR_W     = $clog2(FIFO_DEPTH + 1);

  logic [DATA_W-1:0] ctrlA, ctrlB, misc;
  logic [DATA_W-1:0] bankMem [2][BANK_SPAN];
  logic [DATA_W-1:0] slot [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic              bankSel, softReset, inBank;
  logic [ADDR_W-1:0] bankIdx;

  assign bankSel   = (misc[1:0] == 2'b01);
  assign softReset = strobe.wrEn && strobe.addr == ADDR_MISC && strobe.wrData[DATA_W-1];
  assign inBank    = strobe.addr >= ADDR_BANK_LO && strobe.addr <= ADDR_BANK_HI;
  assign bankIdx   = strobe.addr - ADDR_BANK_LO;

  always_ff @(posedge clk) begin
    if (!rstN || softReset) begin
      ctrlA <= RST_CTRL_A;
      ctrlB <= RST_CTRL_B;
      misc  <= RST_MISC;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < BANK_SPAN; i++) bankMem[b][i] <= '0;
    end else if (strobe.wrEn) begin
      if (strobe.addr == ADDR_CTRL_A) ctrlA <= strobe.wrData;
      if (strobe.addr == ADDR_CTRL_B) ctrlB <= strobe.wrData;
      if (strobe.addr == ADDR_MISC)   misc  <= strobe.wrData;
      if (inBank) bankMem[bankSel][bankIdx] <= strobe.wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrPtr <= '0;
    else if (strobe.fifoRestart) wrPtr <= sampleStrobe ? PTR_W'(1) : '0;
    else if (sampleStrobe && wrPtr < PTR_W'(FIFO_DEPTH)) wrPtr <= wrPtr + PTR_W'(1);
  end

  for (genvar k = 0; k < FIFO_DEPTH; k++) begin : g_slot
    logic hit;
    assign hit = sampleStrobe && (strobe.fifoRestart ? (k == 0) : (wrPtr == PTR_W'(k)));
    always_ff @(posedge clk) begin
      if (!rstN) slot[k] <= '0;
      else if (hit) slot[k] <= sampleByte;
    end
  end

  always_comb begin
    readWord = '0;
    unique case (strobe.addr)
      ADDR_SAMPLE_LO: readWord = {slot[0], slot[1]};
      ADDR_SAMPLE_HI: readWord = {slot[2], slot[3]};
      ADDR_CTRL_A:    readWord = {ctrlA, {DATA_W{1'b0}}};
      ADDR_CTRL_B:    readWord = {ctrlB, {DATA_W{1'b0}}};
      ADDR_MISC:      readWord = {misc, {DATA_W{1'b0}}};
      default: if (strobe.addr >= ADDR_BANK_LO && strobe.addr <= ADDR_BANK_HI)
                 readWord = {bankMem[bankSel][bankIdx], {DATA_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/serialRegPort.sv
module serialRegPort
  import serialRegPkg::*;
#(
  parameter logic [ID_W-1:0] CHIP_ID     = 3'b110,
  parameter int              SYNC_STAGES = 2,
  parameter int              FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spe,
  input  logic              spc,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  input  logic              sampleStrobe,
  input  logic [DATA_W-1:0] sampleByte
);
  portStrobeT          strobe;
  logic [2*DATA_W-1:0] readWord;

  serialPortCtrl #(.CHIP_ID(CHIP_ID), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .spe(spe), .spc(spc), .sdIn(sdIn),
    .readWord(readWord), .strobe(strobe), .sdOut(sdOut), .sdOe(sdOe)
  );

  serialRegData #(.FIFO_DEPTH(FIFO_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleStrobe(sampleStrobe),
    .sampleByte(sampleByte), .readWord(readWord)
  );
endmodule

// File: rtl/serialRegPortChk.sv
module serialRegPortChk
  import serialRegPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int PTR_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              spe,
  input logic              sdOe,
  input portStrobeT        strobe,
  input logic              sampleStrobe,
  input logic              bankSel,
  input logic [DATA_W-1:0] ctrlA,
  input logic [DATA_W-1:0] misc,
  input logic [PTR_W-1:0]  wrPtr
);
  assert_oe_in_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> spe);

  assert_single_commit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.fifoRestart}));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr == ADDR_MISC && strobe.wrData[DATA_W-1])
      |=> (ctrlA == RST_CTRL_A && misc == RST_MISC && !bankSel));

  assert_bank_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr == ADDR_MISC && !strobe.wrData[DATA_W-1])
      |=> (bankSel == ($past(strobe.wrData[1:0]) == 2'b01)));

  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.addr == ADDR_MISC) |=> $stable(bankSel));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fifoRestart && !sampleStrobe) |=> (wrPtr == '0));

  assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_W'(FIFO_DEPTH));
endmodule

bind serialRegPort serialRegPortChk #(.FIFO_DEPTH(FIFO_DEPTH), .PTR_W($clog2(FIFO_DEPTH + 1))) i_chk (
  .clk(clk), .rstN(rstN), .spe(spe), .sdOe(sdOe), .strobe(strobe),
  .sampleStrobe(sampleStrobe), .bankSel(i_data.bankSel), .ctrlA(i_data.ctrlA),
  .misc(i_data.misc), .wrPtr(i_data.wrPtr)
);

// File: tb/test_serialRegPort.sv
module test_serialRegPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spe = 1'b0, spc = 1'b1, sdIn = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [7:0] sampleByte = '0;
  logic sdOut, sdOe;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic oeAfterEnd;
  localparam logic [2:0] ID = 3'b110;

  always #4 clk = ~clk;

  serialRegPort i_serialRegPort (
    .clk(clk), .rstN(rstN), .spe(spe), .spc(spc), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .sampleStrobe(sampleStrobe), .sampleByte(sampleByte)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame of nBits clocks; records the data line and enable just before each rising edge.
  task automatic xfer(input logic [23:0] tx, input int nBits,
                      output logic [23:0] rx, output logic [23:0] oe);
    rx = '0; oe = '0;
    @(negedge clk); spe = 1'b1;
    waitClk(8);
    for (int i = 0; i < nBits; i++) begin
      spc = 1'b0; sdIn = tx[nBits-1-i];
      waitClk(8);
      rx[nBits-1-i] = sdOut;
      oe[nBits-1-i] = sdOe;
      spc = 1'b1;
      waitClk(8);
    end
    spe = 1'b0;
    #1 oeAfterEnd = sdOe;
    waitClk(10);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    logic [23:0] rx, oe;
    xfer({8'h00, 1'b0, ID, a, d}, 16, rx, oe);
  endtask

  task automatic readChk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [23:0] rx, oe;
    xfer({8'h00, 1'b1, ID, a, 8'h00}, 16, rx, oe);
    check(tag, {24'h0, rx[7:0]}, {24'h0, exp});
    check({tag, " R3 enable window"}, {16'h0, oe[15:0]}, 32'h0000_00FF);
  endtask

  task automatic pushSample(input logic [7:0] b);
    @(negedge clk); sampleStrobe = 1'b1; sampleByte = b;
    @(negedge clk); sampleStrobe = 1'b0;
  endtask

  task automatic t_reset;
    check("R4 sdOe idle", {31'h0, sdOe}, 32'h0);
    readChk(4'h4, 8'h40, "R4 ctrlA default");
    readChk(4'h5, 8'h63, "R4 ctrlB default");
    readChk(4'hF, 8'h20, "R4 misc default");
    readChk(4'h9, 8'h00, "R4 banked default");
  endtask

  task automatic t_write;
    writeReg(4'h4, 8'h5A);
    readChk(4'h4, 8'h5A, "R1 ctrlA write");
    writeReg(4'h9, 8'h3C);
    readChk(4'h9, 8'h3C, "R1 banked write");
    writeReg(4'hE, 8'hA5);
    readChk(4'hE, 8'hA5, "R1 top banked write");
  endtask

  task automatic t_badId;
    logic [23:0] rx, oe;
    xfer({8'h00, 1'b0, 3'b101, 4'h4, 8'h11}, 16, rx, oe);
    readChk(4'h4, 8'h5A, "R2 bad id write ignored");
    xfer({8'h00, 1'b1, 3'b010, 4'h4, 8'h00}, 16, rx, oe);
    check("R2 bad id no drive", {8'h0, oe}, 32'h0);
  endtask

  task automatic t_bank;
    writeReg(4'hF, 8'h01);
    readChk(4'h9, 8'h00, "R5 bank1 separate");
    writeReg(4'h9, 8'hC3);
    readChk(4'h4, 8'h5A, "R5 ctrlA common");
    readChk(4'hF, 8'h01, "R5 misc common");
    writeReg(4'hF, 8'h03);
    readChk(4'h9, 8'h3C, "R5 code 11 is bank0");
    writeReg(4'hF, 8'h01);
    readChk(4'h9, 8'hC3, "R5 bank1 kept");
    writeReg(4'hF, 8'h00);
    readChk(4'h9, 8'h3C, "R5 bank0 kept");
  endtask

  task automatic t_unused;
    writeReg(4'h1, 8'hFF);
    readChk(4'h1, 8'h00, "R9 addr1 reads zero");
    writeReg(4'h3, 8'h77);
    readChk(4'h3, 8'h00, "R9 addr3 reads zero");
    writeReg(4'h0, 8'h66);
    readChk(4'h4, 8'h5A, "R9 sample-addr write ignored");
  endtask

  task automatic t_short;
    logic [23:0] rx, oe;
    xfer({8'h00, 4'h0, 1'b0, ID, 4'h5, 4'h1}, 12, rx, oe);
    readChk(4'h5, 8'h63, "R10 short write dropped");
    xfer({8'h00, 4'h0, 1'b1, ID, 4'h4, 4'h0}, 12, rx, oe);
    check("R10 drive before end", {31'h0, oe[0]}, 32'h1);
    check("R10 read partial data", {28'h0, rx[3:0]}, 32'h5);
    check("R10 release at end", {31'h0, oeAfterEnd}, 32'h0);
  endtask

  task automatic t_fifo;
    logic [23:0] rx, oe;
    pushSample(8'hA1); pushSample(8'hA2); pushSample(8'hA3); pushSample(8'hA4);
    pushSample(8'hEE);
    readChk(4'h0, 8'hA1, "R7 short sample read");
    xfer({1'b1, ID, 4'h0, 16'h0}, 24, rx, oe);
    check("R7 low half", {16'h0, rx[15:0]}, 32'hA1A2);
    check("R7 low half enable", {8'h0, oe}, 32'h0000FFFF);
    xfer({1'b1, ID, 4'h2, 16'h0}, 24, rx, oe);
    check("R7 high half, full drops", {16'h0, rx[15:0]}, 32'hA3A4);
    pushSample(8'hB1); pushSample(8'hB2);
    xfer({1'b1, ID, 4'h0, 16'h0}, 24, rx, oe);
    check("R8 restart order", {16'h0, rx[15:0]}, 32'hB1B2);
    xfer({1'b1, ID, 4'h2, 16'h0}, 24, rx, oe);
    check("R8 upper slots untouched", {16'h0, rx[15:0]}, 32'hA3A4);
  endtask

  task automatic t_softReset;
    writeReg(4'h5, 8'h12);
    writeReg(4'hF, 8'h01);
    writeReg(4'h8, 8'h44);
    writeReg(4'hF, 8'h81);
    readChk(4'h4, 8'h40, "R6 ctrlA restored");
    readChk(4'h5, 8'h63, "R6 ctrlB restored");
    readChk(4'hF, 8'h20, "R6 misc restored");
    readChk(4'h9, 8'h00, "R6 bank0 cleared");
    writeReg(4'hF, 8'h01);
    readChk(4'h8, 8'h00, "R6 bank1 cleared");
    writeReg(4'hF, 8'h00);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    t_reset();
    t_write();
    t_badId();
    t_bank();
    t_unused();
    t_short();
    t_fifo();
    t_softReset();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule